// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply-Accumulate Slice

This block is a signed arithmetic slice. It first sums operands A and D in a 25-bit pre-adder. The sum is then multiplied by operand B. The product is extended to 48 bits and added to either the external C operand or the slice's own registered result. The last path lets the slice run as an accumulator. A registered flag rises once the result reaches a power-of-two threshold set by a parameter.

Each pipeline stage is a register slot: A stage 1, A stage 2, B stage 1, B stage 2, D, pre-adder output, product and result. A parameter keeps or removes each slot. Each kept slot loads on the rising clock edge when its enable bit is high. It clears to zero when its synchronous reset bit is high. Both A slots share one enable bit and one reset bit, and so do both B slots. When the pre-adder is turned off, the pre-adder output slot serves as the second A register, so A passes through at most two registers before the multiplier.

Top module: `mac_slice`

## Requirements
- R1: Every register starts at zero, and with all reset bits high it holds zero. After one edge under that reset, `p` is 0 and `ovf` is 0.
- R2: With inputs held steady and all stages enabled, `p` settles to `(c + sext48(preSum * b)) mod 2^48`. In this formula b and c are signed, and `preSum` is the 25-bit signed sum of `a[24:0]` and sign-extended d.
- R3: The pre-adder wraps silently at 25 bits, and A bits above bit 24 have no effect on the result.
- R4: With every stage kept, a change on `b` or `d` first shows on `p` after four rising edges. A change on `a` first shows after five.
- R5: Bit mapping for `ce` and `rst`: bit 0 is the A stages, 1 the B stages, 2 D, 3 the pre-adder output, 4 the product, 5 the result and flag. A register whose `ce` bit is low keeps its value.
- R6: A register whose `rst` bit is high clears to zero on the next edge, whatever its `ce` bit. Other stages are unaffected.
- R7: In accumulate mode, `selC` low makes the post-adder add the registered result to the product on every enabled edge. `selC` high loads `c` plus the product instead.
- R8: `ovf` is registered with `p` and is high exactly when `p`, read as signed, is at least 2^OVF_K (default 2^40).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all stages |
| ce | input | 6 | Per-stage load enables, mapping in R5 |
| rst | input | 6 | Per-stage synchronous clears, same mapping |
| selC | input | 1 | Post-adder source: 1 external C, 0 fed-back result |
| a | input | A_W (30) | Operand A, low 25 bits used |
| b | input | B_W (18) | Signed multiplier operand |
| c | input | P_W (48) | Signed post-adder operand |
| d | input | D_W (25) | Signed pre-adder operand |
| p | output | P_W (48) | Result |
| ovf | output | 1 | Threshold flag |

## Verification
Eight operand sets go through the full pipeline. They mix signs, magnitudes and products that are zero, small, large negative and near the threshold. Because of this mix, a fault in sign extension, truncation or pre-adder wrap gives a different `p`. Values just below and exactly at 2^40 separate a `>=` threshold from a `>` one, and a large negative result shows that the comparison is signed. Directed sequences cover the rest. A single `b` step gives the latency. An accumulate run over several edges separates feedback from load. One-stage enable drops and one-stage resets show which slot holds or clears.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int NUM_STAGES = 6;
  localparam int SEL_A  = 0;
  localparam int SEL_B  = 1;
  localparam int SEL_D  = 2;
  localparam int SEL_AD = 3;
  localparam int SEL_M  = 4;
  localparam int SEL_P  = 5;

  typedef struct packed {
    logic [NUM_STAGES-1:0] load;
    logic [NUM_STAGES-1:0] clear;
    logic                  feedback;
  } stage_strobes_t;
endpackage

// File: rtl/mac_stage.sv
module mac_stage #(
  parameter int W = 8,
  parameter bit PRESENT = 1'b1
) (
  input  logic         clk,
  input  logic         ld,
  input  logic         clr,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] qOut
);
  generate
    if (PRESENT) begin : g_reg
      logic [W-1:0] qReg = '0;
      logic pastValid = 1'b0;
      always_ff @(posedge clk) begin
        pastValid <= 1'b1;
        if (clr)     qReg <= '0;
        else if (ld) qReg <= dIn;
      end
      assign qOut = qReg;

      // R6: a clear strobe leaves the stage at zero
      assert_clear_R6: assert property (@(posedge clk) disable iff (!pastValid)
        clr |=> (qOut == '0));
      // R5: without load or clear the stage holds
      assert_hold_R5: assert property (@(posedge clk) disable iff (!pastValid)
        (!ld && !clr) |=> $stable(qOut));
    end else begin : g_wire
      assign qOut = dIn;
    end
  endgenerate
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter bit ACCUM = 1'b1,
  parameter bit USE_P = 1'b1
) (
  input  logic [NUM_STAGES-1:0] ce,
  input  logic [NUM_STAGES-1:0] rst,
  input  logic                  selC,
  output stage_strobes_t        strobes
);
  localparam bit FEEDBACK_OK = ACCUM && USE_P;

  always_comb begin
    strobes.load     = ce;
    strobes.clear    = rst;
    strobes.feedback = FEEDBACK_OK && !selC;
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int A_W = 30,
  parameter int B_W = 18,
  parameter int D_W = 25,
  parameter int PRE_W = 25,
  parameter int P_W = 48,
  parameter int OVF_K = 40,
  parameter bit USE_PREADD = 1'b1,
  parameter bit USE_A1 = 1'b1,
  parameter bit USE_A2 = 1'b1,
  parameter bit USE_B1 = 1'b1,
  parameter bit USE_B2 = 1'b1,
  parameter bit USE_D = 1'b1,
  parameter bit USE_AD = 1'b1,
  parameter bit USE_M = 1'b1,
  parameter bit USE_P = 1'b1
) (
  input  logic           clk,
  input  stage_strobes_t strobes,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  logic [P_W-1:0] c,
  input  logic [D_W-1:0] d,
  output logic [P_W-1:0] p,
  output logic           ovf
);
  localparam int MULT_W = PRE_W + B_W;
  localparam bit A2_KEPT = USE_A2 && USE_PREADD;
  localparam logic [P_W-1:0] THRESH = P_W'(1) << OVF_K;

  logic [A_W-1:0]    aS1, aS2;
  logic [B_W-1:0]    bS1, bS2;
  logic [D_W-1:0]    dS;
  logic [PRE_W-1:0]  preSum, adOut;
  logic [MULT_W-1:0] product, mOut;
  logic [P_W-1:0]    addend, pNext, pOut;
  logic              ovfNext;

  mac_stage #(.W(A_W), .PRESENT(USE_A1)) u_a1 (.clk(clk), .ld(strobes.load[SEL_A]),
    .clr(strobes.clear[SEL_A]), .dIn(a), .qOut(aS1));
  mac_stage #(.W(A_W), .PRESENT(A2_KEPT)) u_a2 (.clk(clk), .ld(strobes.load[SEL_A]),
    .clr(strobes.clear[SEL_A]), .dIn(aS1), .qOut(aS2));
  mac_stage #(.W(B_W), .PRESENT(USE_B1)) u_b1 (.clk(clk), .ld(strobes.load[SEL_B]),
    .clr(strobes.clear[SEL_B]), .dIn(b), .qOut(bS1));
  mac_stage #(.W(B_W), .PRESENT(USE_B2)) u_b2 (.clk(clk), .ld(strobes.load[SEL_B]),
    .clr(strobes.clear[SEL_B]), .dIn(bS1), .qOut(bS2));
  mac_stage #(.W(D_W), .PRESENT(USE_D)) u_d (.clk(clk), .ld(strobes.load[SEL_D]),
    .clr(strobes.clear[SEL_D]), .dIn(d), .qOut(dS));

  generate
    if (USE_PREADD) begin : g_pre
      assign preSum = PRE_W'(aS2 + A_W'($signed(dS)));
    end else begin : g_nopre
      assign preSum = PRE_W'(aS2);
    end
  endgenerate

  mac_stage #(.W(PRE_W), .PRESENT(USE_AD)) u_ad (.clk(clk), .ld(strobes.load[SEL_AD]),
    .clr(strobes.clear[SEL_AD]), .dIn(preSum), .qOut(adOut));

  assign product = MULT_W'($signed(adOut) * $signed(bS2));

  mac_stage #(.W(MULT_W), .PRESENT(USE_M)) u_m (.clk(clk), .ld(strobes.load[SEL_M]),
    .clr(strobes.clear[SEL_M]), .dIn(product), .qOut(mOut));

  assign addend  = strobes.feedback ? pOut : c;
  assign pNext   = P_W'($signed(mOut)) + addend;
  assign ovfNext = $signed(pNext) >= $signed(THRESH);

  mac_stage #(.W(P_W), .PRESENT(USE_P)) u_p (.clk(clk), .ld(strobes.load[SEL_P]),
    .clr(strobes.clear[SEL_P]), .dIn(pNext), .qOut(pOut));
  mac_stage #(.W(1), .PRESENT(USE_P)) u_ovf (.clk(clk), .ld(strobes.load[SEL_P]),
    .clr(strobes.clear[SEL_P]), .dIn(ovfNext), .qOut(ovf));

  assign p = pOut;

  generate
    if (USE_P) begin : g_chk
      logic pastValid = 1'b0;
      always_ff @(posedge clk) pastValid <= 1'b1;
      // R8: the flag always agrees with the registered result
      assert_ovf_match_R8: assert property (@(posedge clk) disable iff (!pastValid)
        ovf == ($signed(pOut) >= $signed(THRESH)));
      // R7: accumulate step adds the previous product to the previous result
      assert_accum_R7: assert property (@(posedge clk) disable iff (!pastValid)
        (strobes.feedback && strobes.load[SEL_P] && !strobes.clear[SEL_P]) |=>
          (pOut == P_W'($past(pOut) + P_W'($signed($past(mOut))))));
    end
  endgenerate
endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_pkg::*;
#(
  parameter int A_W = 30,
  parameter int B_W = 18,
  parameter int D_W = 25,
  parameter int PRE_W = 25,
  parameter int P_W = 48,
  parameter int OVF_K = 40,
  parameter bit ACCUM = 1'b1,
  parameter bit USE_PREADD = 1'b1,
  parameter bit USE_A1 = 1'b1,
  parameter bit USE_A2 = 1'b1,
  parameter bit USE_B1 = 1'b1,
  parameter bit USE_B2 = 1'b1,
  parameter bit USE_D = 1'b1,
  parameter bit USE_AD = 1'b1,
  parameter bit USE_M = 1'b1,
  parameter bit USE_P = 1'b1
) (
  input  logic                  clk,
  input  logic [NUM_STAGES-1:0] ce,
  input  logic [NUM_STAGES-1:0] rst,
  input  logic                  selC,
  input  logic [A_W-1:0]        a,
  input  logic [B_W-1:0]        b,
  input  logic [P_W-1:0]        c,
  input  logic [D_W-1:0]        d,
  output logic [P_W-1:0]        p,
  output logic                  ovf
);
  stage_strobes_t strobes;

  mac_ctrl #(.ACCUM(ACCUM), .USE_P(USE_P)) u_ctrl (
    .ce(ce), .rst(rst), .selC(selC), .strobes(strobes));

  mac_datapath #(
    .A_W(A_W), .B_W(B_W), .D_W(D_W), .PRE_W(PRE_W), .P_W(P_W), .OVF_K(OVF_K),
    .USE_PREADD(USE_PREADD), .USE_A1(USE_A1), .USE_A2(USE_A2), .USE_B1(USE_B1),
    .USE_B2(USE_B2), .USE_D(USE_D), .USE_AD(USE_AD), .USE_M(USE_M), .USE_P(USE_P)
  ) u_dp (
    .clk(clk), .strobes(strobes), .a(a), .b(b), .c(c), .d(d), .p(p), .ovf(ovf));
endmodule

// File: tb/mac_slice_tb.sv
module mac_slice_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [29:0] va;
    logic [24:0] vd;
    logic [17:0] vb;
    logic [47:0] vc;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{30'd3, 25'd4, 18'd5, 48'd0},
    '{30'h3FFFFFF9, 25'd2, 18'h3FFFD, 48'd100},
    '{30'h0FFFFFF, 25'd1, 18'd2, 48'd0},
    '{30'd0, 25'd0, 18'd0, 48'h00FF_FFFF_FFFF},
    '{30'd0, 25'd0, 18'd0, 48'h0100_0000_0000},
    '{30'd1000, 25'd24, 18'h20000, 48'd5},
    '{30'h3F000001, 25'd1, 18'd7, 48'd0},
    '{30'd0, 25'd0, 18'd0, 48'h8000_0000_0000}
  };

  logic clk = 1'b0;
  logic [5:0] ce = '0, rst = '0;
  logic selC = 1'b1;
  logic [29:0] a = '0;
  logic [17:0] b = '0;
  logic [47:0] c = '0;
  logic [24:0] d = '0;
  logic [47:0] p;
  logic ovf;
  int runCount = 0, failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_slice u_dut (.clk(clk), .ce(ce), .rst(rst), .selC(selC), .a(a), .b(b),
    .c(c), .d(d), .p(p), .ovf(ovf));

  function automatic logic [47:0] expP(vec_t v);
    logic signed [24:0] s;
    logic signed [63:0] prod;
    s = $signed(v.va[24:0]) + $signed(v.vd);
    prod = 64'(s) * 64'($signed(v.vb));
    return 48'(prod) + v.vc;
  endfunction

  function automatic logic expOvf(logic [47:0] val);
    return $signed(val) >= $signed(48'h0100_0000_0000);
  endfunction

  task automatic check(string req, logic [47:0] got, logic [47:0] want);
    runCount++;
    if (got !== want) begin
      failCount++;
      $display("FAIL %s: got %0h expected %0h", req, got, want);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply(vec_t v);
    a = v.va; d = v.vd; b = v.vb; c = v.vc;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    // R1: all stages cleared
    ce = '1; rst = '1;
    a = 30'd9; b = 18'd9; d = 25'd9; c = 48'd9;
    edges(1);
    check("R1 p", p, 48'd0);
    check("R1 ovf", 48'(ovf), 48'd0);
    rst = '0;

    // R2 R3 R8: steady-state table
    foreach (VECS[i]) begin
      apply(VECS[i]);
      edges(6);
      check("R2 R3 p", p, expP(VECS[i]));
      check("R8 ovf", 48'(ovf), 48'(expOvf(expP(VECS[i]))));
    end

    // R4: latency of a b step
    apply('{30'd1, 25'd2, 18'd1, 48'd0});
    edges(6);
    b = 18'd5;
    edges(3);
    check("R4 before", p, 48'd3);
    edges(1);
    check("R4 after", p, 48'd15);

    // R7: load then accumulate
    apply('{30'd1, 25'd2, 18'd1, 48'd10});
    edges(6);
    check("R7 load", p, 48'd13);
    selC = 1'b0;
    edges(4);
    check("R7 accum", p, 48'd25);
    selC = 1'b1;
    edges(1);
    check("R7 reload", p, 48'd13);

    // R5: result stage held with ce bit 5 low
    ce = 6'b011111; c = 48'd100;
    edges(3);
    check("R5 hold", p, 48'd13);
    ce = '1;
    edges(1);
    check("R5 resume", p, 48'd103);

    // R6: clear result only
    rst = 6'b100000;
    edges(1);
    check("R6 p clear", p, 48'd0);
    rst = '0;
    edges(1);
    check("R6 others kept", p, 48'd103);

    // R6: product clear beats enable
    rst = 6'b010000;
    edges(1);
    rst = '0;
    edges(1);
    check("R6 m clear", p, 48'd100);
    edges(1);
    check("R6 m restore", p, 48'd103);

    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule